// File: doc/BRIEF.md
# Prescaled 8-bit Compare Timer

This block is an 8-bit up-counter whose advance rate is taken from a free-running 10-bit divider. One of seven rates, or a stop setting, is selected by a 3-bit field. A single compare channel watches the counter. On a match it can drive a waveform pin (toggle, clear or set) and it raises a sticky interrupt flag. An optional clear-on-match mode turns the counter into a period generator whose period is set by the compare value.

Software reaches the block through a small byte-wide register port with four addresses:
- control: clock select, plus a force strobe that applies the pin action at once;
- counter;
- compare value;
- mode/status.

A write to the counter suppresses the compare on the next counter tick. This keeps a freshly loaded value from producing a match at once.

Top module: `cmp_timer8`

## Requirements
- R1: Clock select (control bits 2:0) gives a one-cycle tick as follows, where k counts clocks since reset. 000 gives no tick. 001 gives a tick every clock. 010/011/100/101/110/111 give a tick on the clocks where k mod 8/32/64/128/256/1024 equals the divisor minus 1.
- R2: On each tick the counter adds one and wraps from 255 to 0. With clock select 000 and no counter write, the counter holds its value.
- R3: Address 1 reads and writes the counter, and the written value is visible on the cycle after the write. A counter write takes priority over a tick in the same cycle.
- R4: A match occurs on a tick when the counter equals the compare value (address 2), the tick is not blocked and the counter is not being written. A match sets the interrupt flag, which reads at address 3 bit 7. Writing 1 to address 3 bit 7 clears the flag, and a match in the same cycle wins.
- R5: Compare mode (address 3 bits 1:0) selects the pin action on a match: 00 leaves the pin alone and the output disabled, 01 toggles it, 10 drives it low and 11 drives it high. The output enable is high for any mode other than 00.
- R6: With clear-on-match (address 3 bit 2) set, a matching tick loads 0 into the counter instead of the incremented value.
- R7: Writing address 0 with bit 7 set applies the current compare-mode pin action at once. It does not set the flag and does not change the counter. The strobe has no effect while the PWM-select bit (address 3 bit 3) is set.
- R8: Reading address 0 returns the clock select in bits 2:0 and zero in bits 7:3.
- R9: After a counter write, the next tick produces no match: the flag does not change, the pin does not change and there is no clear-on-match.
- R10: After reset, the counter, compare value, modes, flag, pin and divider are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 counter, 2 compare, 3 mode/status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wave_out | output | 1 | Waveform pin level |
| wave_oe | output | 1 | Waveform pin output enable |
| irq_flag | output | 1 | Sticky compare-match flag |

## Verification
A wrong divider phase or a wrong tap shows up as a counter read value that drifts from the model within one period of the chosen rate, which is at most 1024 clocks. A wrong block bit or compare-equality path shows within one tick as an extra or missing flag set, pin change or clear-on-match reset. The counter value, flag and pin are compared against a behavioural model on every clock, so a divergence is reported on the first cycle it becomes visible.

// File: rtl/cmp_timer8.sv
module cmp_timer8 #(
  parameter int DIV_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wave_out,
  output logic       wave_oe,
  output logic       irq_flag
);

  logic [DIV_BITS-1:0] presc_q;
  logic [2:0] cs_q;
  logic [1:0] cmode_q;
  logic       ctc_q, pwm_q, flag_q, blk_q, oc_q;
  logic [7:0] cnt_q, cmp_q;
  logic       tick, match, force_cmp, oc_next;

  wire wr_ctl  = wr_en && addr == 2'd0;
  wire wr_cnt  = wr_en && addr == 2'd1;
  wire wr_cmp  = wr_en && addr == 2'd2;
  wire wr_mode = wr_en && addr == 2'd3;

  always_comb begin
    case (cs_q)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd2:    tick = &presc_q[2:0];
      3'd3:    tick = &presc_q[4:0];
      3'd4:    tick = &presc_q[5:0];
      3'd5:    tick = &presc_q[6:0];
      3'd6:    tick = &presc_q[7:0];
      default: tick = &presc_q[DIV_BITS-1:0];
    endcase
  end

  assign match     = tick && !wr_cnt && !blk_q && cnt_q == cmp_q;
  assign force_cmp = wr_ctl && wdata[7] && !pwm_q;

  always_comb begin
    case (cmode_q)
      2'd1:    oc_next = ~oc_q;
      2'd2:    oc_next = 1'b0;
      2'd3:    oc_next = 1'b1;
      default: oc_next = oc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cs_q    <= '0;
      cmode_q <= '0;
      ctc_q   <= 1'b0;
      pwm_q   <= 1'b0;
      cmp_q   <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (wr_ctl) cs_q <= wdata[2:0];
      if (wr_cmp) cmp_q <= wdata;
      if (wr_mode) begin
        cmode_q <= wdata[1:0];
        ctc_q   <= wdata[2];
        pwm_q   <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (wr_cnt) begin
      cnt_q <= wdata;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= (match && ctc_q) ? 8'd0 : cnt_q + 8'd1;
      blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      if (match) flag_q <= 1'b1;
      else if (wr_mode && wdata[7]) flag_q <= 1'b0;
      if (match || force_cmp) oc_q <= oc_next;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {5'b0, cs_q};
      2'd1:    rdata = cnt_q;
      2'd2:    rdata = cmp_q;
      default: rdata = {flag_q, 3'b0, pwm_q, ctc_q, cmode_q};
    endcase
  end

  assign wave_out = oc_q;
  assign wave_oe  = cmode_q != 2'd0;
  assign irq_flag = flag_q;

  assert_ctl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[7:3] == 5'd0);
  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q == 3'd0 && !wr_cnt |=> $stable(cnt_q));
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(wr_mode && wdata[7]) |=> flag_q);
  assert_ctc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_cnt && !blk_q && ctc_q && cnt_q == cmp_q |=> cnt_q == 8'd0);
  assert_force_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !tick && !flag_q |=> !flag_q);
  assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q && tick && !flag_q |=> !flag_q);

endmodule

// File: tb/test_cmp_timer8.sv
module test_cmp_timer8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic wave_out, wave_oe, irq_flag;

  always #5ns clk = ~clk;

  cmp_timer8 i_cmp_timer8 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wave_out(wave_out), .wave_oe(wave_oe),
    .irq_flag(irq_flag));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  logic [1:0] rsel = 0;

  int pc, mcs, mcnt, mcmp, mmode, mctc, mpwm, mflag, mblk, moc;

  function automatic int divisor(int c);
    case (c)
      1: return 1;  2: return 8;   3: return 32;  4: return 64;
      5: return 128; 6: return 256; default: return 1024;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit t, wc, m, f;
    if (!rst_n) begin
      pc = 0; mcs = 0; mcnt = 0; mcmp = 0; mmode = 0; mctc = 0;
      mpwm = 0; mflag = 0; mblk = 0; moc = 0;
    end else begin
      t  = mcs != 0 && (pc % divisor(mcs)) == divisor(mcs) - 1;
      wc = wr_en && addr == 1;
      m  = t && !wc && !mblk && mcnt == mcmp;
      f  = wr_en && addr == 0 && wdata[7] && !mpwm;
      if (m || f) begin
        if (mmode == 1) moc = 1 - moc;
        else if (mmode == 2) moc = 0;
        else if (mmode == 3) moc = 1;
      end
      if (m) mflag = 1;
      else if (wr_en && addr == 3 && wdata[7]) mflag = 0;
      if (wc) begin mcnt = wdata; mblk = 1; end
      else if (t) begin
        mcnt = (m && mctc) ? 0 : (mcnt + 1) % 256;
        mblk = 0;
      end
      if (wr_en && addr == 0) mcs = wdata[2:0];
      if (wr_en && addr == 2) mcmp = wdata;
      if (wr_en && addr == 3) begin
        mmode = wdata[1:0]; mctc = wdata[2]; mpwm = wdata[3];
      end
      pc = (pc + 1) % 1024;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int er;
    @(negedge clk);
    case (addr)
      0: er = mcs;
      1: er = mcnt;
      2: er = mcmp;
      default: er = mflag * 128 + mpwm * 8 + mctc * 4 + mmode;
    endcase
    chk("rdata", rdata, er);
    chk("wave_out", wave_out, moc);
    chk("wave_oe", wave_oe, mmode != 0);
    chk("irq_flag", irq_flag, mflag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    cyc();
    wr_en = 1; addr = a[1:0]; wdata = d[7:0];
    cyc();
    wr_en = 0; addr = rsel;
  endtask

  initial begin
    #2ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R10"; idle(2);
    for (int a = 0; a < 4; a++) begin addr = a[1:0]; idle(1); end
    cur_req = "R8"; rsel = 0; addr = 0;
    wr(0, 8'h81); idle(2);
    wr(0, 8'h7A); idle(3);
    wr(0, 0);
    cur_req = "R2"; rsel = 1; addr = 1;
    wr(2, 8'hF0); wr(0, 1); idle(300);
    wr(0, 0); idle(20);
    cur_req = "R1";
    for (int c = 2; c < 8; c++) begin
      wr(0, c);
      idle(c == 7 ? 2200 : (c == 6 ? 800 : 400));
    end
    cur_req = "R5"; rsel = 3; wr(0, 0); wr(1, 0); wr(2, 10);
    for (int md = 0; md < 4; md++) begin
      wr(3, md); wr(0, 1); idle(300); wr(0, 0);
    end
    cur_req = "R4";
    wr(3, 8'h81); idle(3);
    wr(0, 1); idle(270);
    wr(3, 8'h81); idle(5); wr(0, 0);
    cur_req = "R6"; rsel = 1;
    wr(3, 8'h05); wr(2, 20); wr(1, 0); wr(0, 2); idle(600);
    cur_req = "R3"; wr(0, 0); wr(1, 8'hAB); idle(4); wr(1, 3); idle(2);
    cur_req = "R9"; wr(0, 1); wr(1, 20); idle(5); wr(1, 19); idle(300);
    cur_req = "R7"; rsel = 3; wr(0, 0); wr(3, 8'h81);
    wr(0, 8'h80); idle(2); wr(0, 8'h80); idle(2);
    wr(3, 2); wr(0, 8'h80); wr(3, 3); wr(0, 8'h80);
    wr(3, 8'h09); wr(0, 8'h80); idle(2);
    wr(3, 1); wr(2, 5); wr(1, 5); wr(0, 8'h81); idle(20);
    wr(0, 0); idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule